// File: doc/BRIEF.md
# Activity Monitor with Consecutive-Breach and Average-Band Interrupts

The block watches a stream of single-cycle activity pulses from a memory-traffic counter. It turns them into one weighted sample per sampling period and raises interrupts when the traffic leaves a programmed band. Each sampling period lasts a programmable number of clock cycles. During a period, every cycle with the activity pulse high adds a programmable weight to an accumulator. At the end of the period the accumulated value becomes the period's sample, and the accumulator restarts from zero.

Each sample feeds two independent checks. The raw check compares the sample against an upper and a lower watermark. It flags an event only after the sample has been beyond the same watermark for a programmable run of consecutive periods. The average check keeps an exponential running average with a programmable window. It flags an event when the updated average moves above or below its own pair of watermarks. Events latch into a status register that software clears by writing ones. The interrupt output is raised while any latched event has its enable set.

Software drives the block through a simple register port. Writes take effect at the clock edge where the write strobe is high. Reads are combinational on the address. The register port and the activity input are plain control pins with no handshake. Every cycle's write and every cycle's pulse is taken, so there is no back-pressure to manage.

Top module: `amon_top`

## Requirements
- R1: After reset every register reads zero, including the status and the running average, and `irq` is low.
- R2: With the global enable (control bit 31) and the sampling enable (bit 18) set, a sample is taken every PERIOD+1 cycles, where PERIOD is the value at offset 0x40. The sample equals the weight at offset 0x18 times the number of cycles in that period on which `act_pulse` was high. PERIOD of zero samples every cycle.
- R3: Status bit 31 sets when the sample is strictly greater than the raw upper watermark (offset 0x04) for N+1 consecutive samples, where N is control bits 28:26. A sample equal to the watermark is not a breach.
- R4: Status bit 30 sets when the sample is strictly below the raw lower watermark (offset 0x08) for N+1 consecutive samples, where N is control bits 25:23.
- R5: A sample back inside a watermark restarts that watermark's run from zero. After a run fires, it counts again from zero, so with N=1 it fires on every second breaching sample.
- R6: Writing offset 0x0C seeds the running average. Each sample then updates it as avg + ((sample − avg) >>> (K+1)), computed as a signed value, with K in control bits 12:10. The current average reads at offset 0x20.
- R7: Status bit 29 sets when an updated average is strictly above the average upper watermark (offset 0x10). Status bit 28 sets when it is strictly below the average lower watermark (offset 0x14).
- R8: Writing the status register (offset 0x24) clears each of bits 31:28 written as one and leaves the others. An event in the same cycle wins over the clear.
- R9: `irq` is high exactly when a status bit is set and its enable is set. The pairings are bit 31 with control bit 30, bit 30 with bit 29, bit 29 with bit 21, and bit 28 with bit 20. A status bit with its enable clear does not raise `irq`.
- R10: While the global enable is clear, the accumulator holds zero and no sample is taken. The run counters and the average hold their values, except that a seed write still loads the average. With the sampling enable clear, no sample is taken either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| act_pulse | input | 1 | One activity event per high cycle |
| irq | output | 1 | Level interrupt |

## Verification
Take the edge that writes the global enable as edge 0. Sample k then covers the pulses seen at edges (k−1)(P+1)+1 through k(P+1), and its status bits and average appear after edge k(P+1)+1. This is one register stage for the sample and one for the status and average. Each directed task starts its count at that enabling write. It samples on the falling edge just before and just after the edge it has worked out, so an early or a late result is caught. Status clears and control rewrites take effect after their own write edge, and they are checked on the following falling edge.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int REG_W = 32;
  localparam int NUM_W = 3;
  localparam int KV_W  = 3;
  localparam int NEVT  = 4;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RAW_HI = 8'h04;
  localparam logic [7:0] OFS_RAW_LO = 8'h08;
  localparam logic [7:0] OFS_SEED   = 8'h0C;
  localparam logic [7:0] OFS_AVG_HI = 8'h10;
  localparam logic [7:0] OFS_AVG_LO = 8'h14;
  localparam logic [7:0] OFS_WEIGHT = 8'h18;
  localparam logic [7:0] OFS_AVG    = 8'h20;
  localparam logic [7:0] OFS_STAT   = 8'h24;
  localparam logic [7:0] OFS_PERIOD = 8'h40;

  localparam int B_GEN      = 31;
  localparam int B_UP_EN    = 30;
  localparam int B_DN_EN    = 29;
  localparam int B_UP_NUM   = 26;
  localparam int B_DN_NUM   = 23;
  localparam int B_AVUP_EN  = 21;
  localparam int B_AVDN_EN  = 20;
  localparam int B_PERIODIC = 18;
  localparam int B_KV       = 10;
  localparam int B_STAT_LO  = 28;

  localparam logic [REG_W-1:0] CTRL_MASK = 32'hFFB4_1C00;

  // event index: 3 raw above, 2 raw below, 1 avg above, 0 avg below
  typedef struct packed {
    logic                 gen;
    logic                 periodic;
    logic [1:0]           run_en;
    logic [1:0][NUM_W-1:0] run_num;
    logic                 avup_en;
    logic                 avdn_en;
    logic [KV_W-1:0]      kv;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.gen        = w[B_GEN];
    c.periodic   = w[B_PERIODIC];
    c.run_en     = {w[B_DN_EN], w[B_UP_EN]};
    c.run_num[0] = w[B_UP_NUM +: NUM_W];
    c.run_num[1] = w[B_DN_NUM +: NUM_W];
    c.avup_en    = w[B_AVUP_EN];
    c.avdn_en    = w[B_AVDN_EN];
    c.kv         = w[B_KV +: KV_W];
    return c;
  endfunction
endpackage

// File: rtl/amon_regs.sv
module amon_regs
  import amon_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NEVT-1:0]     evt,
  input  logic [REG_W-1:0]    avg_val,
  output logic [REG_W-1:0]    ctrl_q,
  output logic [REG_W-1:0]    raw_hi_q,
  output logic [REG_W-1:0]    raw_lo_q,
  output logic [REG_W-1:0]    avg_hi_q,
  output logic [REG_W-1:0]    avg_lo_q,
  output logic [REG_W-1:0]    weight_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic                seed_wr,
  output logic [NEVT-1:0]     status_q,
  output logic                irq
);
  logic [REG_W-1:0] seed_q;
  logic [NEVT-1:0]  clr_mask;
  logic [NEVT-1:0]  en_mask;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign seed_wr  = reg_wr && hit(reg_addr, OFS_SEED);
  assign clr_mask = (reg_wr && hit(reg_addr, OFS_STAT)) ? reg_wdata[B_STAT_LO +: NEVT] : '0;
  assign en_mask  = {ctrl_q[B_UP_EN], ctrl_q[B_DN_EN], ctrl_q[B_AVUP_EN], ctrl_q[B_AVDN_EN]};
  assign irq      = |(status_q & en_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      raw_hi_q <= '0;
      raw_lo_q <= '0;
      avg_hi_q <= '0;
      avg_lo_q <= '0;
      weight_q <= '0;
      period_q <= '0;
      seed_q   <= '0;
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt;
      if (reg_wr) begin
        if (hit(reg_addr, OFS_CTRL))   ctrl_q   <= reg_wdata & CTRL_MASK;
        if (hit(reg_addr, OFS_RAW_HI)) raw_hi_q <= reg_wdata;
        if (hit(reg_addr, OFS_RAW_LO)) raw_lo_q <= reg_wdata;
        if (hit(reg_addr, OFS_AVG_HI)) avg_hi_q <= reg_wdata;
        if (hit(reg_addr, OFS_AVG_LO)) avg_lo_q <= reg_wdata;
        if (hit(reg_addr, OFS_WEIGHT)) weight_q <= reg_wdata;
        if (hit(reg_addr, OFS_PERIOD)) period_q <= reg_wdata[PERIOD_W-1:0];
        if (hit(reg_addr, OFS_SEED))   seed_q   <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFS_CTRL))   reg_rdata = ctrl_q;
    if (hit(reg_addr, OFS_RAW_HI)) reg_rdata = raw_hi_q;
    if (hit(reg_addr, OFS_RAW_LO)) reg_rdata = raw_lo_q;
    if (hit(reg_addr, OFS_AVG_HI)) reg_rdata = avg_hi_q;
    if (hit(reg_addr, OFS_AVG_LO)) reg_rdata = avg_lo_q;
    if (hit(reg_addr, OFS_WEIGHT)) reg_rdata = weight_q;
    if (hit(reg_addr, OFS_PERIOD)) reg_rdata = REG_W'(period_q);
    if (hit(reg_addr, OFS_SEED))   reg_rdata = seed_q;
    if (hit(reg_addr, OFS_AVG))    reg_rdata = avg_val;
    if (hit(reg_addr, OFS_STAT))   reg_rdata = {status_q, {B_STAT_LO{1'b0}}};
  end
endmodule

// File: rtl/amon_sampler.sv
module amon_sampler
  import amon_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic [REG_W-1:0]    weight,
  input  logic                act,
  output logic [REG_W-1:0]    acc_q,
  output logic [REG_W-1:0]    sample_q,
  output logic                sample_v
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [REG_W:0]      acc_wide;
  logic [REG_W-1:0]    acc_in;
  logic                tick;

  assign acc_wide = {1'b0, acc_q} + (act ? {1'b0, weight} : '0);
  assign acc_in   = acc_wide[REG_W] ? '1 : acc_wide[REG_W-1:0];
  assign tick     = run && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      sample_q <= '0;
      sample_v <= 1'b0;
    end else begin
      sample_v <= tick;
      if (!run) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (tick) begin
        cnt_q    <= '0;
        acc_q    <= '0;
        sample_q <= acc_in;
      end else begin
        cnt_q <= cnt_q + PERIOD_W'(1);
        acc_q <= acc_in;
      end
    end
  end
endmodule

// File: rtl/amon_run.sv
module amon_run
  import amon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen,
  input  logic             step,
  input  logic             breach,
  input  logic [NUM_W-1:0] limit,
  output logic             fire
);
  logic [NUM_W-1:0] cnt_q;

  assign fire = gen && step && breach && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (gen && step)
      cnt_q <= (!breach || fire) ? '0 : cnt_q + NUM_W'(1);
  end
endmodule

// File: rtl/amon_eval.sv
module amon_eval
  import amon_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gen,
  input  logic                  sample_v,
  input  logic [REG_W-1:0]      sample,
  input  logic [REG_W-1:0]      raw_hi,
  input  logic [REG_W-1:0]      raw_lo,
  input  logic [1:0][NUM_W-1:0] run_num,
  input  logic [KV_W-1:0]       kv,
  input  logic [REG_W-1:0]      avg_hi,
  input  logic [REG_W-1:0]      avg_lo,
  input  logic                  seed_wr,
  input  logic [REG_W-1:0]      seed_val,
  output logic [REG_W-1:0]      avg_q,
  output logic [NEVT-1:0]       evt
);
  logic [1:0]             breach;
  logic [1:0]             fire;
  logic signed [REG_W:0]  diff;
  logic signed [REG_W:0]  delta;
  logic signed [REG_W:0]  avg_sum;
  logic [REG_W-1:0]       avg_nxt;
  logic                   upd;

  assign breach[0] = sample > raw_hi;
  assign breach[1] = sample < raw_lo;

  for (genvar i = 0; i < 2; i++) begin : g_run
    amon_run u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .gen    (gen),
      .step   (sample_v),
      .breach (breach[i]),
      .limit  (run_num[i]),
      .fire   (fire[i])
    );
  end

  assign upd     = gen && sample_v;
  assign diff    = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
  assign delta   = diff >>> ({1'b0, kv} + 4'd1);
  assign avg_sum = $signed({1'b0, avg_q}) + delta;
  assign avg_nxt = avg_sum[REG_W-1:0];

  assign evt = {fire[0], fire[1], upd && (avg_nxt > avg_hi), upd && (avg_nxt < avg_lo)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      avg_q <= '0;
    else if (seed_wr)
      avg_q <= seed_val;
    else if (upd)
      avg_q <= avg_nxt;
  end
endmodule

// File: rtl/amon_top.sv
module amon_top
  import amon_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              act_pulse,
  output logic              irq
);
  logic [REG_W-1:0]    ctrl_q, raw_hi_q, raw_lo_q, avg_hi_q, avg_lo_q, weight_q;
  logic [PERIOD_W-1:0] period_q;
  logic                seed_wr;
  logic [NEVT-1:0]     status_q, evt;
  logic [REG_W-1:0]    avg_q, acc_q, sample_q;
  logic                sample_v;
  ctrl_t               cfg;

  assign cfg = decode_ctrl(ctrl_q);

  amon_regs #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .avg_val(avg_q),
    .ctrl_q(ctrl_q), .raw_hi_q(raw_hi_q), .raw_lo_q(raw_lo_q),
    .avg_hi_q(avg_hi_q), .avg_lo_q(avg_lo_q), .weight_q(weight_q),
    .period_q(period_q), .seed_wr(seed_wr), .status_q(status_q), .irq(irq)
  );

  amon_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .run(cfg.gen && cfg.periodic), .period(period_q),
    .weight(weight_q), .act(act_pulse), .acc_q(acc_q), .sample_q(sample_q),
    .sample_v(sample_v)
  );

  amon_eval u_eval (
    .clk(clk), .rst_n(rst_n), .gen(cfg.gen), .sample_v(sample_v),
    .sample(sample_q), .raw_hi(raw_hi_q), .raw_lo(raw_lo_q),
    .run_num(cfg.run_num), .kv(cfg.kv), .avg_hi(avg_hi_q), .avg_lo(avg_lo_q),
    .seed_wr(seed_wr), .seed_val(reg_wdata), .avg_q(avg_q), .evt(evt)
  );
endmodule

// File: rtl/amon_checker.sv
module amon_checker
  import amon_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic                irq,
  input logic [REG_W-1:0]    ctrl_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic                seed_wr,
  input logic [NEVT-1:0]     status_q,
  input logic [NEVT-1:0]     evt,
  input logic [REG_W-1:0]    avg_q,
  input logic [REG_W-1:0]    acc_q,
  input logic                sample_v
);
  // R2: a nonzero period never yields samples on adjacent cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_v && period_q != '0) |=> !sample_v);

  // R3: run and average events only appear on a sample cycle
  p_evt_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> sample_v);

  // R8: a full clear with no event in flight empties the status
  p_full_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[31:28] == 4'hF && evt == '0)
    |=> status_q == '0);

  // R9: with every interrupt enable clear the interrupt stays low
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_UP_EN] && !ctrl_q[B_DN_EN] && !ctrl_q[B_AVUP_EN] && !ctrl_q[B_AVDN_EN])
    |-> !irq);

  // R10: disabled block keeps its average unless seeded
  p_avg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_GEN] && !seed_wr) |=> $stable(avg_q));

  // R10: disabled block holds the accumulator at zero
  p_acc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_GEN] |=> acc_q == '0);
endmodule

bind amon_top amon_checker #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_amon_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .ctrl_q(ctrl_q), .period_q(period_q),
  .seed_wr(seed_wr), .status_q(status_q), .evt(evt), .avg_q(avg_q),
  .acc_q(acc_q), .sample_v(sample_v)
);

// File: tb/amon_top_bench.sv
module amon_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        act_pulse = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_HI = 8'h04, A_LO = 8'h08, A_SEED = 8'h0C,
                         A_AHI = 8'h10, A_ALO = 8'h14, A_WT = 8'h18, A_AVG = 8'h20,
                         A_ST = 8'h24, A_PER = 8'h40;

  always #2 clk = ~clk;

  amon_top u_amon_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_pulse(act_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit gen, input bit upen, input bit dnen,
                                     input int upn, input int dnn, input bit aue,
                                     input bit ade, input bit per, input int k);
    logic [31:0] w = 32'h0;
    w[31] = gen; w[30] = upen; w[29] = dnen;
    w[28:26] = upn[2:0]; w[25:23] = dnn[2:0];
    w[21] = aue; w[20] = ade; w[18] = per; w[12:10] = k[2:0];
    return w;
  endfunction

  // ends at the enabling write (edge 0); act is applied before it
  task automatic setup(input int per, input int wt, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] ahi, input logic [31:0] alo, input logic [31:0] seed,
                       input bit act, input logic [31:0] ctrl);
    wr(A_CTRL, 32'h0);
    wr(A_PER, per); wr(A_WT, wt); wr(A_HI, hi); wr(A_LO, lo);
    wr(A_AHI, ahi); wr(A_ALO, alo); wr(A_SEED, seed); wr(A_ST, 32'hFFFF_FFFF);
    act_pulse = act;
    wr(A_CTRL, ctrl);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_ST, d);   chk("R1 status", d, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_AVG, d);  chk("R1 avg", d, 0);
    rd(A_PER, d);  chk("R1 period", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_above();
    logic [31:0] d;
    setup(3, 5, 15, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,1,0,2,0,0,0,1,0));
    edges(12); rd(A_ST, d); chk("R3 before third breach", d[31], 0);
    chk("R9 irq idle", irq, 0);
    edges(1);  rd(A_ST, d); chk("R3 third breach", d[31], 1);
    chk("R9 irq on above", irq, 1);
  endtask

  task automatic t_boundary();
    logic [31:0] d;
    setup(3, 7, 28, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,1,0,0,0,0,0,1,0));
    edges(5); rd(A_ST, d); chk("R3 equal is no breach", d[31], 0);
    setup(3, 7, 27, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,1,0,0,0,0,0,1,0));
    edges(4); rd(A_ST, d); chk("R2 sample not yet due", d[31], 0);
    edges(1); rd(A_ST, d); chk("R2 weighted sample 28", d[31], 1);
  endtask

  task automatic t_below_restart();
    logic [31:0] d;
    setup(1, 3, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 0, 0, 0, cw(1,0,1,0,1,0,0,1,0));
    edges(4); rd(A_ST, d); chk("R4 before second low", d[30], 0);
    edges(1); rd(A_ST, d); chk("R4 second low", d[30], 1);
    chk("R9 irq on below", irq, 1);
    wr(A_ST, 32'hFFFF_FFFF);
    edges(1); rd(A_ST, d); chk("R5 restart after fire", d[30], 0);
    edges(2); rd(A_ST, d); chk("R5 fires again", d[30], 1);
  endtask

  task automatic t_run_reset();
    logic [31:0] d;
    setup(3, 5, 15, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,1,0,1,0,0,0,1,0));
    edges(4); act_pulse = 0;
    edges(4); act_pulse = 1;
    edges(5); rd(A_ST, d); chk("R5 inside sample resets run", d[31], 0);
    edges(4); rd(A_ST, d); chk("R5 two fresh breaches", d[31], 1);
  endtask

  task automatic t_avg();
    logic [31:0] d;
    setup(3, 5, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,0,0,0,0,0,0,1,1));
    edges(5); rd(A_AVG, d); chk("R6 avg rise 1", d, 5);
    edges(4); rd(A_AVG, d); chk("R6 avg rise 2", d, 8);
    setup(3, 5, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 100, 0, cw(1,0,0,0,0,0,0,1,0));
    rd(A_AVG, d); chk("R6 seed", d, 100);
    edges(5); rd(A_AVG, d); chk("R6 avg fall 1", d, 50);
    edges(4); rd(A_AVG, d); chk("R6 avg fall 2", d, 25);
    setup(0, 3, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 0, 1, cw(1,0,0,0,0,0,0,1,0));
    edges(2); rd(A_AVG, d); chk("R2 zero period sample 1", d, 1);
    edges(1); rd(A_AVG, d); chk("R2 zero period sample 2", d, 2);
  endtask

  task automatic t_avg_evt();
    logic [31:0] d;
    setup(3, 5, 32'hFFFF_FFFF, 0, 200, 60, 100, 0, cw(1,0,0,0,0,0,0,1,0));
    edges(5); rd(A_ST, d);
    chk("R7 avg below", d[28], 1);
    chk("R7 avg not above", d[29], 0);
    chk("R9 masked below", irq, 0);
    wr(A_CTRL, cw(1,0,0,0,0,0,1,1,0));
    chk("R9 enabled below", irq, 1);
    setup(3, 5, 32'hFFFF_FFFF, 0, 5, 0, 0, 1, cw(1,0,0,0,0,1,0,1,0));
    edges(5); rd(A_ST, d);
    chk("R7 avg above", d[29], 1);
    chk("R9 irq avg above", irq, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    setup(3, 5, 32'hFFFF_FFFF, 1, 200, 60, 100, 0, cw(1,0,1,0,0,0,0,1,0));
    edges(5); rd(A_ST, d); chk("R8 two bits set", d, 32'h5000_0000);
    wr(A_ST, 32'h4000_0000);
    rd(A_ST, d); chk("R8 selective clear", d, 32'h1000_0000);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R8 full clear", d, 0);
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    setup(1, 5, 0, 0, 32'hFFFF_FFFF, 0, 40, 1, cw(1,1,0,0,0,0,0,1,0));
    edges(3); rd(A_AVG, d); chk("R10 avg before disable", d, 25);
    wr(A_CTRL, cw(0,1,0,0,0,0,0,1,0));
    wr(A_ST, 32'hFFFF_FFFF);
    edges(10);
    rd(A_AVG, d); chk("R10 avg frozen", d, 25);
    rd(A_ST, d);  chk("R10 no events when off", d, 0);
    chk("R10 irq when off", irq, 0);
    setup(1, 5, 0, 0, 32'hFFFF_FFFF, 0, 40, 1, cw(1,1,0,0,0,0,0,0,0));
    edges(10);
    rd(A_AVG, d); chk("R10 no sampling without periodic", d, 40);
    rd(A_ST, d);  chk("R10 no status without periodic", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_above();
    t_boundary();
    t_below_restart();
    t_run_reset();
    t_avg();
    t_avg_evt();
    t_w1c();
    t_freeze();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule